// File: doc/BRIEF.md
# Convolutional Byte De-interleaver

This block restores the original byte order of a stream that was spread by a twelve-branch convolutional interleaver with a delay unit of seventeen bytes. Bytes arrive one per accepted strobe, already byte aligned, with a marker on the first byte of each 204-byte block. A commutator deals each byte to one of twelve circular buffers. Branch `j` holds `(11 - j) * 17` bytes, so branch 0 (the sync byte's branch) delays most and branch 11 passes straight through. The byte that leaves a branch is the one written into it that many slots earlier.

A block of 204 bytes is exactly twelve rounds of seventeen. A delay of `k * 17` slots in one branch is therefore exactly `k` whole blocks. Byte `N` of a block is held back `(203 - N) mod 12` blocks, and the stream leaves in original order, eleven blocks late. The block-start marker realigns the commutator. Between markers the commutator keeps counting by itself. Output is withheld until the deepest branch has refilled after the most recent realignment.

Top module: `dil_deinterleaver`

## Requirements
- R1: `out_valid` rises exactly one clock after an accepted input byte (`in_valid` = 1) and never without one. Output data and marker appear in that same cycle.
- R2: Byte `N` (0..203) of a block is delayed by `(11 - N mod 12)` blocks. The output is therefore the original stream delayed by exactly eleven blocks, byte for byte.
- R3: An accepted byte is routed to branch `index mod 12`. A byte accepted with `in_start` = 1 has index 0 and uses branch 0. Branch `j` holds `(11 - j) * 17` bytes, and branch 11 holds none.
- R4: `out_start` = 1 on exactly the output bytes whose block index is 0, and only while `out_valid` = 1.
- R5: No byte is output before the first `in_start`. After a realignment, no byte is output until eleven full blocks have been accepted, so output resumes at index 0 of the twelfth block.
- R6: Cycles with `in_valid` = 0 are ignored entirely, whatever `in_data` and `in_start` carry. They neither advance the commutator nor touch any buffer.
- R7: When the index wraps from 203 to 0 with `in_start` = 0, the block continues as if the marker had been present. Output stays valid and correct.
- R8: An `in_start` that arrives at a non-zero expected index forces index 0 and branch 0 and restarts the fill wait of R5. `out_valid` = 0 for the byte that carried it.
- R9: While reset is low (active-low `rst_n`), `out_valid`, `out_start` and `out_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input byte strobe |
| in_start | input | 1 | Marks the first byte (index 0) of a block |
| in_data | input | W | Interleaved input byte |
| out_valid | output | 1 | Output byte strobe |
| out_start | output | 1 | Output byte has block index 0 |
| out_data | output | W | De-interleaved output byte |

## Verification
Three things can fall on the same accepted byte: a block boundary reached by the counter, an external marker, and the end of the fill wait. When they agree (aligned marker at index 0 on the twelfth block), the same byte must both mark `out_start` and be the first valid output. When a marker lands mid-block, realignment must win over the running count and blank the output. The bench provokes the aligned case with and without the marker on one block. It provokes the conflicting case by breaking a block off after a hundred bytes. Idle cycles carrying stray markers are mixed in throughout. A scoreboard built from an independent interleaver model judges every output byte, its marker and its cycle. Any valid output while the scoreboard expects nothing is counted as a failure.

// File: rtl/dil_pkg.sv
package dil_pkg;
   // Number of storage slots in branch j of a B-branch, U-byte-unit de-interleaver
   function automatic int branch_depth(input int j, input int b, input int u);
      return (b - 1 - j) * u;
   endfunction
endpackage

// File: rtl/dil_branch_fifo.sv
module dil_branch_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 17
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   if (DEPTH < 0) begin : g_bad_depth
      $error("dil_branch_fifo: DEPTH must not be negative");
   end

   if (DEPTH == 0) begin : g_wire
      logic unused_dep0;
      assign unused_dep0 = ^{clk, rst_n, en};
      assign dout = din;
   end else begin : g_ring
      localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
      logic [W-1:0]  mem [DEPTH];
      logic [PW-1:0] ptr;

      always_ff @(posedge clk) begin
         if (en) mem[ptr] <= din;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          ptr <= '0;
         else if (en && ptr == PW'(DEPTH-1))  ptr <= '0;
         else if (en)                         ptr <= ptr + 1'b1;
      end

      assign dout = mem[ptr];

      p_ptr_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
         32'(ptr) < DEPTH);
      p_ptr_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
         !en |=> $stable(ptr));
   end
endmodule

// File: rtl/dil_commutator.sv
module dil_commutator #(
   parameter int BRANCHES = 12,
   parameter int UNIT     = 17
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        in_valid,
   input  logic                        in_start,
   output logic [$clog2(BRANCHES)-1:0] sel,
   output logic                        first_byte,
   output logic                        wr_ok,
   output logic                        ready,
   output logic                        misalign
);
   localparam int BLK = BRANCHES * UNIT;
   localparam int IW  = $clog2(BLK);
   localparam int BW  = $clog2(BRANCHES);
   localparam int FW  = $clog2(BRANCHES);
   localparam logic [FW-1:0] FULL = FW'(BRANCHES - 1);

   logic [IW-1:0] nxt_idx, idx_cur;
   logic [BW-1:0] nxt_br, br_cur;
   logic          locked;
   logic [FW-1:0] fill, fill_cur;

   always_comb begin
      idx_cur  = in_start ? '0 : nxt_idx;
      br_cur   = in_start ? '0 : nxt_br;
      wr_ok    = locked | in_start;
      misalign = in_start & locked & (nxt_idx != '0);
      if (in_start && (!locked || misalign))  fill_cur = '0;
      else if (wr_ok && idx_cur == '0 && fill != FULL) fill_cur = fill + 1'b1;
      else                                    fill_cur = fill;
   end

   assign sel        = br_cur;
   assign first_byte = (idx_cur == '0);
   assign ready      = wr_ok && (fill_cur == FULL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nxt_idx <= '0;
         nxt_br  <= '0;
         locked  <= 1'b0;
         fill    <= '0;
      end else if (in_valid) begin
         nxt_idx <= (idx_cur == IW'(BLK-1))     ? '0 : idx_cur + 1'b1;
         nxt_br  <= (br_cur  == BW'(BRANCHES-1)) ? '0 : br_cur  + 1'b1;
         locked  <= wr_ok;
         fill    <= fill_cur;
      end
   end

   p_branch_tracks_index_r3: assert property (@(posedge clk) disable iff (!rst_n)
      32'(nxt_br) == (32'(nxt_idx) % BRANCHES));
   p_idle_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(nxt_idx) && $stable(fill));
   p_resync_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && misalign |=> fill == '0);
endmodule

// File: rtl/dil_deinterleaver.sv
module dil_deinterleaver #(
   parameter int W        = 8,
   parameter int BRANCHES = 12,
   parameter int UNIT     = 17
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   input  logic         in_start,
   input  logic [W-1:0] in_data,
   output logic         out_valid,
   output logic         out_start,
   output logic [W-1:0] out_data
);
   localparam int BW = $clog2(BRANCHES);

   if (BRANCHES < 2 || UNIT < 1 || W < 1) begin : g_bad_param
      $error("dil_deinterleaver: need BRANCHES >= 2, UNIT >= 1, W >= 1");
   end

   logic [BW-1:0] sel;
   logic          first_byte, wr_ok, ready, misalign;
   logic [W-1:0]  rd [BRANCHES];

   dil_commutator #(.BRANCHES(BRANCHES), .UNIT(UNIT)) u_comm (
      .clk, .rst_n, .in_valid, .in_start,
      .sel, .first_byte, .wr_ok, .ready, .misalign
   );

   for (genvar j = 0; j < BRANCHES; j++) begin : g_branch
      dil_branch_fifo #(.W(W), .DEPTH(dil_pkg::branch_depth(j, BRANCHES, UNIT))) u_fifo (
         .clk, .rst_n,
         .en   (in_valid && wr_ok && sel == BW'(j)),
         .din  (in_data),
         .dout (rd[j])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_start <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= in_valid && ready;
         out_start <= in_valid && ready && first_byte;
         if (in_valid && ready) out_data <= rd[sel];
      end
   end

   p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid));
   p_start_in_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
      out_start |-> out_valid);
   p_misalign_blanks_r8: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && misalign |=> !out_valid);
endmodule

// File: tb/dil_deinterleaver_bench.sv
module dil_deinterleaver_bench;
   localparam int NB  = 12;
   localparam int BLK = 204;

   typedef struct packed {
      int unsigned stamp;
      logic        st;
      logic [7:0]  d;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0, in_start = 1'b0;
   logic [7:0] in_data = '0;
   logic       out_valid, out_start;
   logic [7:0] out_data;

   int unsigned cyc = 0;
   int checks = 0, errors = 0, unexpected = 0, starts_seen = 0, starts_exp = 0;
   int gap = 0;
   bit done = 0;
   exp_t q[$];

   always #10 clk = ~clk;  // 50 MHz
   always @(posedge clk) cyc <= cyc + 1;

   dil_deinterleaver u_dil_deinterleaver (
      .clk, .rst_n, .in_valid, .in_start, .in_data,
      .out_valid, .out_start, .out_data
   );

   function automatic logic [7:0] orig(input int k, input int n);
      if (k < 0)  return 8'hE0 ^ 8'(n);
      if (n == 0) return 8'h47;
      return 8'(k * 37 + n * 11 + 5);
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, expv, cyc);
      end
   endtask

   // one accepted byte, plus occasional idle cycles carrying junk and stray markers (R6)
   task automatic send(input logic st, input logic [7:0] d, input bit push, input logic [7:0] ed, input logic es);
      gap++;
      if (gap % 7 == 3) begin
         @(negedge clk);
         in_valid = 1'b0; in_start = 1'b1; in_data = 8'h5A;
      end
      @(negedge clk);
      in_valid = 1'b1; in_start = st; in_data = d;
      if (push) begin
         q.push_back('{stamp: cyc + 1, st: es, d: ed});
         if (es) starts_exp++;
      end
   endtask

   // tx block t relative to the current alignment origin; bytes [0, nbytes)
   task automatic send_block(input int t, input bit mark, input int nbytes);
      for (int n = 0; n < nbytes; n++)
         send(mark && n == 0, orig(t - (n % NB), n), t >= NB - 1, orig(t - (NB - 1), n), n == 0);
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (out_start) starts_seen++;
         if (q.size() == 0) begin
            unexpected++;
            check(0, "R5 R8 out_valid with nothing expected", 1, 0);
         end else begin
            exp_t e;
            e = q.pop_front();
            check(cyc == e.stamp, "R1 output cycle", cyc, e.stamp);
            check(out_data == e.d, "R2 R3 R7 data", out_data, e.d);
            check(out_start == e.st, "R4 start marker", out_start, e.st);
         end
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      wait (cyc > 150000);
      check(0, "watchdog expired", int'(cyc), 0);
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      check(out_valid == 0 && out_start == 0 && out_data == 0, "R9 reset outputs",
            {out_valid, out_start, out_data}, 0);
      rst_n = 1'b1;
      // R5: junk before any marker
      for (int i = 0; i < 30; i++) send(1'b0, 8'(i * 13), 0, 8'h0, 1'b0);
      // origin A; block 6 carries no marker (R7)
      for (int t = 0; t < 15; t++) send_block(t, t != 6, BLK);
      // block 15 broken off after 100 bytes, still expected
      send_block(15, 1'b1, 100);
      // origin B: marker at non-zero expected index (R8), refill
      for (int t = 0; t < 13; t++) send_block(t, 1'b1, BLK);
      @(negedge clk);
      in_valid = 1'b0; in_start = 1'b0;
      repeat (4) @(negedge clk);
      check(q.size() == 0, "R2 all expected bytes produced", q.size(), 0);
      check(unexpected == 0, "R5 R8 no output during fill", unexpected, 0);
      check(starts_seen == starts_exp, "R4 start marker count", starts_seen, starts_exp);
      check(starts_exp == 4 + 1 + 2, "R5 fill length in blocks", starts_exp, 7);
      finish_run();
   end
endmodule